// File: doc/BRIEF.md
# Boot Configuration Loader

This block runs once after reset. It acts for a short time as the master of a two-wire SMBus/I2C bus and copies a 256-byte configuration image out of an external serial EEPROM. Each byte that arrives goes out on a one-cycle write port with its index, so that a configuration register file can store it. When the copy ends, or when the EEPROM does not acknowledge, the block releases the bus and signals that the device may run as a bus target at its default address.

The bus pins are open-drain. The block only pulls SCL or SDA low through its enable outputs and reads the resolved SDA level back. The sequence is fixed:
- a quiet period with both lines released;
- START, the EEPROM write address and word offset zero;
- a repeated START with the EEPROM read address;
- 256 reads, each acknowledged except the final one, which gets a NACK;
- STOP.

If any of the three bytes the master sends goes without an acknowledge, the block ends the transfer with STOP, flags the load as failed and raises an alert request. The alert is held until the host reads the status register once.

Top module: `boot_cfg_loader`

## Requirements
- R1: While reset is held, both bus enables, the write strobe, done, failed, alert and target-enable outputs are low.
- R2: After reset is released, neither bus line is pulled for exactly WAIT_CYCLES clock cycles. The first pull appears after WAIT_CYCLES rising edges.
- R3: The first transfer is START, then byte 0xA0 (7-bit address 1010000 followed by a 0 write bit, MSB first), then byte 0x00. SDA changes only while SCL is pulled low, except in START and STOP. An acknowledge is sampled after each byte.
- R4: When both write-phase bytes are acknowledged, a repeated START follows, then byte 0xA1 (the same address with the read bit set to 1). There are exactly two STARTs in a successful load.
- R5: 256 data bytes are read. The master drives ACK (SDA low) after bytes 0 to 254 and NACK (SDA released) after byte 255, and then sends exactly one STOP.
- R6: Each byte read is presented with cfg_idx equal to its position (0 to 255) and cfg_data holding the byte, MSB first on the wire, on a cfg_we strobe that lasts one cycle. Byte N is presented before byte N+1.
- R7: After a successful load, load_done and tgt_en are high, load_fail and alert_req are low, and tgt_addr reads 0101111 (0x2F).
- R8: If the EEPROM leaves SDA high in the acknowledge slot of any byte the master sends (0xA0, 0x00 or 0xA1), the block stops sending bytes and issues one STOP. It then raises load_fail, alert_req and tgt_en, keeps load_done low, and makes no cfg_we strobe.
- R9: A raised alert_req stays high until a one-cycle status_rd pulse arrives, and that single pulse clears it.
- R10: A status_rd pulse has no effect on alert_req before the alert is raised. A pulse that falls in the same cycle in which the alert is raised leaves alert_req high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sda_i | input | 1 | Resolved SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| cfg_we | output | 1 | One-cycle write strobe for a received byte |
| cfg_idx | output | 8 | Index of the received byte |
| cfg_data | output | 8 | Received byte |
| load_done | output | 1 | Image loaded completely |
| load_fail | output | 1 | Load aborted on a missing acknowledge |
| alert_req | output | 1 | Alert request after a failed load |
| status_rd | input | 1 | Pulse: the host has read the status register |
| tgt_en | output | 1 | Bus handed back; target mode may start |
| tgt_addr | output | 7 | Target address to use in target mode |

## Verification
Two events can fall in the same clock edge: the host's status read, which clears the alert, and the end of the STOP after a failed load, which raises it. The bench first runs a failing load and measures the cycle in which the alert appears. It then repeats the identical load from reset with a status_rd pulse timed to be sampled on exactly that edge. The result passes only if alert_req is still high afterwards and a later pulse clears it. A pulse sent during the quiet period of a failing load must likewise leave the later alert untouched.

// File: rtl/boot_cfg_loader.sv
module boot_cfg_loader #(
  parameter int         WAIT_CYCLES = 2_500_000,
  parameter int         QTR_CYCLES  = 625,
  parameter logic [6:0] ROM_ADDR    = 7'b1010000,
  parameter logic [6:0] TGT_ADDR    = 7'b0101111
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       cfg_we,
  output logic [7:0] cfg_idx,
  output logic [7:0] cfg_data,
  output logic       load_done,
  output logic       load_fail,
  output logic       alert_req,
  input  logic       status_rd,
  output logic       tgt_en,
  output logic [6:0] tgt_addr
);
  localparam int WW = $clog2(WAIT_CYCLES + 1);
  localparam int QW = $clog2(QTR_CYCLES + 1);

  typedef enum logic [2:0] {S_WAIT, S_START, S_TX, S_RX, S_STOP, S_IDLE} st_t;

  st_t         st;
  logic [WW-1:0] wcnt;
  logic [QW-1:0] qcnt;
  logic [1:0]  ph;
  logic [3:0]  bitn;
  logic [1:0]  txsel;
  logic [7:0]  rcnt, shreg, txbyte;
  logic        fail;

  wire tick    = (qcnt == QW'(QTR_CYCLES - 1));
  wire samp    = tick && (ph == 2'd2);
  wire bit_end = tick && (ph == 2'd3);
  wire is_ack  = (bitn == 4'd8);
  wire last    = (rcnt == 8'hFF);

  assign tgt_en   = (st == S_IDLE);
  assign tgt_addr = TGT_ADDR;

  always_comb begin
    case (txsel)
      2'd0:    txbyte = {ROM_ADDR, 1'b0};
      2'd1:    txbyte = 8'h00;
      default: txbyte = {ROM_ADDR, 1'b1};
    endcase
  end

  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    case (st)
      S_START: begin scl_oe = (ph == 2'd0) || (ph == 2'd3); sda_oe = (ph >= 2'd2); end
      S_TX:    begin scl_oe = (ph == 2'd0) || (ph == 2'd3);
                     sda_oe = !is_ack && !txbyte[3'd7 - bitn[2:0]]; end
      S_RX:    begin scl_oe = (ph == 2'd0) || (ph == 2'd3); sda_oe = is_ack && !last; end
      S_STOP:  begin scl_oe = (ph == 2'd0); sda_oe = (ph <= 2'd1); end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_WAIT; wcnt <= '0; qcnt <= '0; ph <= 2'd0; bitn <= 4'd0;
      txsel <= 2'd0; rcnt <= 8'd0; shreg <= 8'd0; fail <= 1'b0;
      cfg_we <= 1'b0; cfg_idx <= 8'd0; cfg_data <= 8'd0;
      load_done <= 1'b0; load_fail <= 1'b0; alert_req <= 1'b0;
    end else begin
      cfg_we <= 1'b0;
      if (status_rd) alert_req <= 1'b0;
      if (st == S_WAIT) begin
        qcnt <= '0;
        if (wcnt == WW'(WAIT_CYCLES - 1)) st <= S_START;
        else wcnt <= wcnt + 1'b1;
      end else if (st != S_IDLE) begin
        qcnt <= tick ? '0 : qcnt + 1'b1;
        if (tick) ph <= ph + 2'd1;
        if (samp) begin
          if (st == S_TX && is_ack && sda_i) fail <= 1'b1;
          if (st == S_RX && !is_ack) begin
            shreg <= {shreg[6:0], sda_i};
            if (bitn == 4'd7) begin
              cfg_we   <= 1'b1;
              cfg_idx  <= rcnt;
              cfg_data <= {shreg[6:0], sda_i};
            end
          end
        end
        if (bit_end) begin
          case (st)
            S_START: begin st <= S_TX; bitn <= 4'd0; end
            S_TX: begin
              if (!is_ack) bitn <= bitn + 4'd1;
              else begin
                bitn <= 4'd0;
                if (fail)               st <= S_STOP;
                else if (txsel == 2'd1) begin txsel <= 2'd2; st <= S_START; end
                else if (txsel == 2'd2) st <= S_RX;
                else                    txsel <= 2'd1;
              end
            end
            S_RX: begin
              if (!is_ack) bitn <= bitn + 4'd1;
              else begin
                bitn <= 4'd0;
                if (last) st <= S_STOP;
                else      rcnt <= rcnt + 8'd1;
              end
            end
            S_STOP: begin
              st        <= S_IDLE;
              load_done <= !fail;
              load_fail <= fail;
              if (fail) alert_req <= 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end

  assert_wait_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT) |-> (!scl_oe && !sda_oe));
  assert_sda_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TX && !scl_oe && $past(st == S_TX) && $past(!scl_oe)) |-> $stable(sda_oe));
  assert_we_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> !cfg_we);
  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> (load_done && tgt_en));
  assert_fail_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_fail |-> (!load_done && !cfg_we));
  assert_alert_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alert_req) |-> load_fail);
  assert_alert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (alert_req && !status_rd) |=> alert_req);
endmodule

// File: tb/tb_boot_cfg_loader.sv
`timescale 1ns/1ps
module tb_boot_cfg_loader;
  localparam int WAITC = 40;
  localparam int QTR   = 2;

  logic clk = 1'b0, rst_n = 1'b0, status_rd = 1'b0;
  logic scl_oe, sda_oe, cfg_we, load_done, load_fail, alert_req, tgt_en;
  logic [7:0] cfg_idx, cfg_data;
  logic [6:0] tgt_addr;
  logic sl_low = 1'b0;
  wire scl_ln = !scl_oe;
  wire sda_ln = !(sda_oe || sl_low);

  always #2 clk = ~clk;

  boot_cfg_loader #(.WAIT_CYCLES(WAITC), .QTR_CYCLES(QTR)) dut (
    .clk(clk), .rst_n(rst_n), .sda_i(sda_ln), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .load_done(load_done), .load_fail(load_fail), .alert_req(alert_req),
    .status_rd(status_rd), .tgt_en(tgt_en), .tgt_addr(tgt_addr));

  function automatic logic [7:0] fmem(input logic [7:0] p);
    return (p * 8'd37) ^ 8'h5C;
  endfunction

  int nchk = 0, nbad = 0;
  bit ended = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // EEPROM responder
  int nack_cfg = 0;
  logic ps = 1'b1, pd = 1'b1, act = 1'b0, nakd = 1'b0, mack = 1'b0;
  int bn = 0, role = 0, pend = 0, nrx = 0, nstart = 0, nstop = 0, nmack = 0, nmnack = 0;
  logic [7:0] sh = 8'd0, ptr = 8'd0, cur = 8'd0;
  logic [7:0] lg [0:3];

  always @(negedge clk) begin
    if (!rst_n) begin
      act = 0; sl_low = 0; bn = 0; nrx = 0; nstart = 0; nstop = 0;
      nmack = 0; nmnack = 0; nakd = 0; ps = 1; pd = 1;
    end else begin
      if (ps && scl_ln && pd && !sda_ln) begin
        act = 1; bn = 0; role = 0; sl_low = 0; nakd = 0; nstart++;
      end else if (ps && scl_ln && !pd && sda_ln) begin
        act = 0; sl_low = 0; nstop++;
      end else if (act && !ps && scl_ln) begin
        bn++;
        if (bn <= 8 && role != 2) sh = {sh[6:0], sda_ln};
        if (bn == 9 && role == 2) begin
          mack = !sda_ln;
          if (mack) nmack++; else nmnack++;
        end
      end else if (act && ps && !scl_ln) begin
        if (bn == 8 && role != 2) begin
          if (nrx < 4) lg[nrx] = sh;
          nrx++;
          nakd = (nrx == nack_cfg);
          sl_low = !nakd;
          if (role == 0) pend = sh[0] ? 2 : 1;
          else begin ptr = sh; pend = 3; end
        end else if (bn == 8 && role == 2) begin
          sl_low = 0;
        end else if (bn == 9) begin
          bn = 0; sl_low = 0;
          if (nakd) act = 0;
          else if (role != 2) begin
            role = pend;
            if (role == 2) begin cur = fmem(ptr); sl_low = !cur[7]; end
          end else if (mack) begin
            ptr++; cur = fmem(ptr); sl_low = !cur[7];
          end
        end else if (role == 2 && bn >= 1 && bn <= 7) begin
          sl_low = !cur[7 - bn];
        end
      end
      ps = scl_ln; pd = sda_ln;
    end
  end

  // write port monitor
  int nwr = 0, werr = 0;
  always @(negedge clk) begin
    if (!rst_n) begin nwr = 0; werr = 0; end
    else if (cfg_we) begin
      if (cfg_idx != nwr[7:0] || cfg_data != fmem(nwr[7:0])) werr++;
      nwr++;
    end
  end

  localparam int NV = 4;
  localparam int V_NACK [NV] = '{0, 1, 2, 3};
  localparam int V_DONE [NV] = '{1, 0, 0, 0};
  localparam int V_STRT [NV] = '{2, 1, 1, 2};
  localparam int V_RXB  [NV] = '{3, 1, 2, 3};
  localparam int V_WR   [NV] = '{256, 0, 0, 0};

  int first_act, tdone;

  task automatic do_reset();
    rst_n = 0; status_rd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic run(input int nk, input int rd_at);
    int n;
    nack_cfg = nk;
    do_reset();
    n = 0; first_act = -1;
    while (!tgt_en && n < 40000) begin
      @(negedge clk); n++;
      if ((scl_oe || sda_oe) && first_act < 0) first_act = n;
      status_rd = (n == rd_at);
    end
    status_rd = 0;
    tdone = n;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1; nchk++; nbad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    int tfail;
    // R1 reset state
    rst_n = 0;
    repeat (2) @(negedge clk);
    chk(!scl_oe && !sda_oe, "R1 bus released in reset", {scl_oe, sda_oe}, 0);
    chk(!cfg_we && !load_done && !load_fail, "R1 flags low in reset", {cfg_we, load_done, load_fail}, 0);
    chk(!alert_req && !tgt_en, "R1 alert/target low in reset", {alert_req, tgt_en}, 0);

    for (int v = 0; v < NV; v++) begin
      run(V_NACK[v], -1);
      @(negedge clk);
      if (v == 0) chk(first_act == WAITC, "R2 quiet period length", first_act, WAITC);
      chk(load_done == V_DONE[v][0], "R7/R8 load_done", load_done, V_DONE[v]);
      chk(load_fail == !V_DONE[v][0], "R8 load_fail", load_fail, !V_DONE[v][0]);
      chk(alert_req == !V_DONE[v][0], "R8 alert_req", alert_req, !V_DONE[v][0]);
      chk(tgt_en && tgt_addr == 7'h2F, "R7 target address", tgt_addr, 'h2F);
      chk(nstart == V_STRT[v], "R4 START count", nstart, V_STRT[v]);
      chk(nstop == 1, "R5/R8 STOP count", nstop, 1);
      chk(nrx == V_RXB[v], "R3/R8 bytes sent by master", nrx, V_RXB[v]);
      chk(lg[0] == 8'hA0, "R3 write address byte", lg[0], 'hA0);
      if (V_RXB[v] >= 2) chk(lg[1] == 8'h00, "R3 offset byte", lg[1], 0);
      if (V_RXB[v] >= 3) chk(lg[2] == 8'hA1, "R4 read address byte", lg[2], 'hA1);
      chk(nwr == V_WR[v], "R6/R8 write strobes", nwr, V_WR[v]);
      chk(werr == 0, "R6 index and data", werr, 0);
      if (v == 0) begin
        chk(nmack == 255, "R5 master ACK count", nmack, 255);
        chk(nmnack == 1, "R5 master NACK count", nmnack, 1);
      end
    end

    // R9 hold then single read clears
    run(1, -1);
    tfail = tdone;
    repeat (20) @(negedge clk);
    chk(alert_req, "R9 alert held", alert_req, 1);
    status_rd = 1; @(negedge clk); status_rd = 0; @(negedge clk);
    chk(!alert_req, "R9 single read clears", alert_req, 0);
    chk(load_fail && tgt_en, "R9 fail kept after read", load_fail, 1);

    // R10 read in the same cycle the alert is raised
    run(1, tfail - 1);
    chk(tdone == tfail, "R10 repeatable timing", tdone, tfail);
    @(negedge clk);
    chk(alert_req, "R10 same-cycle read keeps alert", alert_req, 1);
    status_rd = 1; @(negedge clk); status_rd = 0; @(negedge clk);
    chk(!alert_req, "R10 later read clears", alert_req, 0);

    // R10 read before any alert has no effect
    run(3, 5);
    @(negedge clk);
    chk(alert_req, "R10 early read ignored", alert_req, 1);

    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end
endmodule